// File: doc/BRIEF.md
# Tagged Register File with Spill and Fill Collection

This block is a small general-register file. Each data register carries one extra tag bit that marks a deferred exception. A speculative load that would fault does not trap. It leaves the target register zeroed and tagged, and the tag travels with the value until something consumes it. A normal store of a tagged register raises a consumption fault. A tag test or a recovery check reports the tag without consuming it.

Spill and fill move registers through ordinary untagged memory without losing the tag. The tag is parked in a 64-bit collection register. The bit used is picked by address bits 8:3 of the spill or fill. Software can read and load the collection register through its own port, so it can save and restore the register around a spill or fill sequence.

One operation is accepted per cycle. Memory is treated as combinational: read data and the fault flag for the request arrive in the same cycle. Register, tag and collection updates take effect at the next clock edge. The fault, test and recovery outputs are registered, one-cycle pulses.

Top module: `tagreg_spill_unit`

## Requirements
- R1: After a synchronous active-low reset, every register reads data 0 with a clear tag, the collection register is 0, no memory request is issued, and all pulse outputs are low.
- R2: op_code values are: 0 idle, 1 register write, 2 load, 3 speculative load, 4 store, 5 spill, 6 fill, 7 tag test, 8 recovery check; other values do nothing. A register write stores op_wdata into op_rd and clears its tag, visible on the read port after the next edge.
- R3: Register 0 always reads data 0 with a clear tag. Any write, load or fill aimed at it has no effect.
- R4: A load issues a read request at op_addr in the same cycle. It writes mem_rdata into op_rd and clears that register's tag.
- R5: A speculative load with mem_fault high leaves op_rd with data 0 and tag set. Without mem_fault it behaves as a load.
- R6: A store of an untagged op_rs issues a write of its data at op_addr. A store of a tagged op_rs issues no memory request, and consume_fault pulses in the next cycle.
- R7: An aligned spill writes op_rs to op_addr, or all zeros if op_rs is tagged. It copies the tag of op_rs into collection bit op_addr[8:3].
- R8: An aligned fill writes mem_rdata into op_rd and sets its tag from collection bit op_addr[8:3].
- R9: A spill or fill with op_addr[2:0] not zero issues no memory request and changes no register, tag or collection bit. align_fault pulses in the next cycle.
- R10: coll_rdata always shows the collection register. coll_wr_en loads coll_wdata at the edge. If a spill lands in the same cycle, the spill's bit overrides the software value for that one bit.
- R11: A tag test of op_rs drives tag_test_valid high and tag_test_result equal to the tag of op_rs in the next cycle.
- R12: A recovery check of op_rs pulses recover_req in the next cycle only if op_rs is tagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation selector |
| op_rd | input | 5 | Target register index |
| op_rs | input | 5 | Source register index |
| op_addr | input | 16 | Memory byte address |
| op_wdata | input | 64 | Data for register write |
| rd_idx | input | 5 | Read port index |
| rd_data | output | 64 | Read port data |
| rd_tag | output | 1 | Read port tag |
| mem_req_valid | output | 1 | Memory request this cycle |
| mem_req_write | output | 1 | Request is a write |
| mem_addr | output | 16 | Request address |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, same cycle |
| mem_fault | input | 1 | Request would fault, same cycle |
| coll_wr_en | input | 1 | Load collection register |
| coll_wdata | input | 64 | Value to load |
| coll_rdata | output | 64 | Collection register contents |
| tag_test_valid | output | 1 | Tag test result present |
| tag_test_result | output | 1 | Tested tag |
| recover_req | output | 1 | Recovery needed |
| consume_fault | output | 1 | Tagged value stored normally |
| align_fault | output | 1 | Misaligned spill or fill |

## Verification
A lost or stray tag bit is invisible on the data path until a later operation consumes it. It then shows up as a missing or extra consume_fault, a wrong tag_test_result, or a wrong recover_req one cycle after that operation. A wrong tag also shows on the read port right after the edge that wrote it. A wrong collection bit is visible on coll_rdata one cycle after the spill. Its effect on a register tag appears only after a later fill reads it back. So the bench reads back the target after every operation and later re-fills and tests the same slots.

// File: rtl/tsu_pkg.sv
// Shared operation codes and registered flag bundle for the tagged
// register unit. Assumes a 4-bit operation field.
package tsu_pkg;

    typedef enum logic [3:0] {
        OP_IDLE      = 4'd0,
        OP_WRITE     = 4'd1,
        OP_LOAD      = 4'd2,
        OP_SPEC_LOAD = 4'd3,
        OP_STORE     = 4'd4,
        OP_SPILL     = 4'd5,
        OP_FILL      = 4'd6,
        OP_TAG_TEST  = 4'd7,
        OP_CHECK     = 4'd8
    } tsu_op_e;

    typedef struct packed {
        logic align;
        logic consume;
        logic test_v;
        logic test_bit;
        logic recover;
    } tsu_flags_t;

endpackage

// File: rtl/tsu_regfile.sv
// Register file with one tag bit per entry. Entry 0 has no storage and
// reads as zero with a clear tag. One write port, two combinational read
// ports. Assumes NREG is a power of two.
module tsu_regfile #(
    parameter int NREG = 32,
    parameter int DW   = 64,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic          wtag,
    input  logic [IW-1:0] ridx_a,
    output logic [DW-1:0] rdata_a,
    output logic          rtag_a,
    input  logic [IW-1:0] ridx_b,
    output logic [DW-1:0] rdata_b,
    output logic          rtag_b
);

    logic [NREG*DW-1:0] data_flat;
    logic [NREG-1:0]    tag_vec;

    for (genvar g = 0; g < NREG; g++) begin : g_ent
        if (g == 0) begin : g_zero
            assign data_flat[g*DW +: DW] = '0;
            assign tag_vec[g]            = 1'b0;
        end else begin : g_store
            logic [DW-1:0] d_q;
            logic          t_q;
            // Hold one entry; reset clears data and tag.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    d_q <= '0;
                    t_q <= 1'b0;
                end else if (we && widx == IW'(g)) begin
                    d_q <= wdata;
                    t_q <= wtag;
                end
            end
            assign data_flat[g*DW +: DW] = d_q;
            assign tag_vec[g]            = t_q;
        end
    end

    // Observation port.
    always_comb begin
        rdata_a = data_flat[int'(ridx_a)*DW +: DW];
        rtag_a  = tag_vec[ridx_a];
    end

    // Source operand port.
    always_comb begin
        rdata_b = data_flat[int'(ridx_b)*DW +: DW];
        rtag_b  = tag_vec[ridx_b];
    end

endmodule

// File: rtl/tsu_collect.sv
// Collection register that parks tag bits during spill and fill.
// A software load and a hardware single-bit update may share a cycle.
// The hardware bit then wins for its position.
module tsu_collect #(
    parameter int CW   = 64,
    localparam int CIW = $clog2(CW)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sw_we,
    input  logic [CW-1:0]  sw_wdata,
    input  logic           hw_set_en,
    input  logic [CIW-1:0] hw_idx,
    input  logic           hw_bit,
    input  logic [CIW-1:0] sel_idx,
    output logic           sel_bit,
    output logic [CW-1:0]  q
);

    logic [CW-1:0] nxt;

    // Merge the software load with the spill bit update.
    always_comb begin
        nxt = sw_we ? sw_wdata : q;
        if (hw_set_en) begin
            nxt[hw_idx] = hw_bit;
        end
    end

    // Hold the collection value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end

    // Bit picked for a fill.
    assign sel_bit = q[sel_idx];

endmodule

// File: rtl/tsu_decode.sv
// Combinational operation decode. It forms the memory request, the
// register write, the collection update and the flags for the next cycle.
// Assumes memory answers in the same cycle as the request.
module tsu_decode
    import tsu_pkg::*;
#(
    parameter int DW       = 64,
    parameter int AW       = 16,
    parameter int IW       = 5,
    parameter int CIW      = 6,
    parameter int COLL_LSB = 3
) (
    input  logic           op_valid,
    input  logic [3:0]     op_code,
    input  logic [IW-1:0]  op_rd,
    input  logic [AW-1:0]  op_addr,
    input  logic [DW-1:0]  op_wdata,
    input  logic [DW-1:0]  mem_rdata,
    input  logic           mem_fault,
    input  logic [DW-1:0]  src_data,
    input  logic           src_tag,
    input  logic           coll_bit,
    output logic           mem_req_valid,
    output logic           mem_req_write,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    output logic           rf_we,
    output logic [IW-1:0]  rf_widx,
    output logic [DW-1:0]  rf_wdata,
    output logic           rf_wtag,
    output logic           coll_set_en,
    output logic [CIW-1:0] coll_idx,
    output logic           coll_val,
    output tsu_flags_t     flags_nxt
);

    logic    aligned;
    tsu_op_e op;

    assign aligned  = (op_addr[COLL_LSB-1:0] == '0);
    assign op       = tsu_op_e'(op_code);
    assign mem_addr = op_addr;
    assign rf_widx  = op_rd;
    assign coll_idx = op_addr[COLL_LSB +: CIW];
    assign coll_val = src_tag;

    // Decode one operation into its side effects.
    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_wdata     = '0;
        rf_we         = 1'b0;
        rf_wdata      = '0;
        rf_wtag       = 1'b0;
        coll_set_en   = 1'b0;
        flags_nxt     = '0;
        if (op_valid) begin
            case (op)
                OP_WRITE: begin
                    rf_we    = 1'b1;
                    rf_wdata = op_wdata;
                end
                OP_LOAD: begin
                    mem_req_valid = 1'b1;
                    rf_we         = 1'b1;
                    rf_wdata      = mem_rdata;
                end
                OP_SPEC_LOAD: begin
                    mem_req_valid = 1'b1;
                    rf_we         = 1'b1;
                    rf_wdata      = mem_fault ? '0 : mem_rdata;
                    rf_wtag       = mem_fault;
                end
                OP_STORE: begin
                    if (src_tag) begin
                        flags_nxt.consume = 1'b1;
                    end else begin
                        mem_req_valid = 1'b1;
                        mem_req_write = 1'b1;
                        mem_wdata     = src_data;
                    end
                end
                OP_SPILL: begin
                    if (!aligned) begin
                        flags_nxt.align = 1'b1;
                    end else begin
                        mem_req_valid = 1'b1;
                        mem_req_write = 1'b1;
                        mem_wdata     = src_tag ? '0 : src_data;
                        coll_set_en   = 1'b1;
                    end
                end
                OP_FILL: begin
                    if (!aligned) begin
                        flags_nxt.align = 1'b1;
                    end else begin
                        mem_req_valid = 1'b1;
                        rf_we         = 1'b1;
                        rf_wdata      = mem_rdata;
                        rf_wtag       = coll_bit;
                    end
                end
                OP_TAG_TEST: begin
                    flags_nxt.test_v   = 1'b1;
                    flags_nxt.test_bit = src_tag;
                end
                OP_CHECK: begin
                    flags_nxt.recover = src_tag;
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/tagreg_spill_unit.sv
// Top of the tagged register unit. It accepts one operation per cycle.
// Register, tag and collection updates land at the next edge. Flags are
// registered pulses. Assumes AW covers address bits 8:3.
module tagreg_spill_unit
    import tsu_pkg::*;
#(
    parameter int NREG = 32,
    parameter int DW   = 64,
    parameter int AW   = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    op_valid,
    input  logic [3:0]              op_code,
    input  logic [$clog2(NREG)-1:0] op_rd,
    input  logic [$clog2(NREG)-1:0] op_rs,
    input  logic [AW-1:0]           op_addr,
    input  logic [DW-1:0]           op_wdata,
    input  logic [$clog2(NREG)-1:0] rd_idx,
    output logic [DW-1:0]           rd_data,
    output logic                    rd_tag,
    output logic                    mem_req_valid,
    output logic                    mem_req_write,
    output logic [AW-1:0]           mem_addr,
    output logic [DW-1:0]           mem_wdata,
    input  logic [DW-1:0]           mem_rdata,
    input  logic                    mem_fault,
    input  logic                    coll_wr_en,
    input  logic [63:0]             coll_wdata,
    output logic [63:0]             coll_rdata,
    output logic                    tag_test_valid,
    output logic                    tag_test_result,
    output logic                    recover_req,
    output logic                    consume_fault,
    output logic                    align_fault
);

    localparam int IW       = $clog2(NREG);
    localparam int CW       = 64;
    localparam int CIW      = $clog2(CW);
    localparam int COLL_LSB = 3;

    logic [DW-1:0]  src_data;
    logic           src_tag;
    logic           rf_we;
    logic [IW-1:0]  rf_widx;
    logic [DW-1:0]  rf_wdata;
    logic           rf_wtag;
    logic           coll_set_en;
    logic [CIW-1:0] coll_idx;
    logic           coll_val;
    logic           coll_bit;
    tsu_flags_t     flags_nxt;
    tsu_flags_t     flags_q;

    tsu_regfile #(.NREG(NREG), .DW(DW)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .widx    (rf_widx),
        .wdata   (rf_wdata),
        .wtag    (rf_wtag),
        .ridx_a  (rd_idx),
        .rdata_a (rd_data),
        .rtag_a  (rd_tag),
        .ridx_b  (op_rs),
        .rdata_b (src_data),
        .rtag_b  (src_tag)
    );

    tsu_collect #(.CW(CW)) u_coll (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_we     (coll_wr_en),
        .sw_wdata  (coll_wdata),
        .hw_set_en (coll_set_en),
        .hw_idx    (coll_idx),
        .hw_bit    (coll_val),
        .sel_idx   (op_addr[COLL_LSB +: CIW]),
        .sel_bit   (coll_bit),
        .q         (coll_rdata)
    );

    tsu_decode #(
        .DW(DW), .AW(AW), .IW(IW), .CIW(CIW), .COLL_LSB(COLL_LSB)
    ) u_dec (
        .op_valid      (op_valid),
        .op_code       (op_code),
        .op_rd         (op_rd),
        .op_addr       (op_addr),
        .op_wdata      (op_wdata),
        .mem_rdata     (mem_rdata),
        .mem_fault     (mem_fault),
        .src_data      (src_data),
        .src_tag       (src_tag),
        .coll_bit      (coll_bit),
        .mem_req_valid (mem_req_valid),
        .mem_req_write (mem_req_write),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .rf_we         (rf_we),
        .rf_widx       (rf_widx),
        .rf_wdata      (rf_wdata),
        .rf_wtag       (rf_wtag),
        .coll_set_en   (coll_set_en),
        .coll_idx      (coll_idx),
        .coll_val      (coll_val),
        .flags_nxt     (flags_nxt)
    );

    // Register the per-operation flags as one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_nxt;
        end
    end

    assign align_fault     = flags_q.align;
    assign consume_fault   = flags_q.consume;
    assign tag_test_valid  = flags_q.test_v;
    assign tag_test_result = flags_q.test_bit;
    assign recover_req     = flags_q.recover;

endmodule

// File: rtl/tsu_chk.sv
// Property checker for the tagged register unit, bound to the top.
module tsu_chk #(
    parameter int NREG = 32,
    parameter int DW   = 64,
    parameter int AW   = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    op_valid,
    input logic [3:0]              op_code,
    input logic [AW-1:0]           op_addr,
    input logic                    src_tag,
    input logic [$clog2(NREG)-1:0] rd_idx,
    input logic [DW-1:0]           rd_data,
    input logic                    rd_tag,
    input logic                    mem_req_valid,
    input logic                    mem_req_write,
    input logic [DW-1:0]           mem_wdata,
    input logic                    align_fault,
    input logic                    consume_fault,
    input logic                    tag_test_valid,
    input logic                    recover_req
);

    logic sf_op;
    logic misal;
    assign sf_op = op_valid && (op_code == 4'd5 || op_code == 4'd6);
    assign misal = sf_op && (op_addr[2:0] != 3'b0);

    AST_ZERO_REG_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_idx == '0 |-> (rd_data == '0 && !rd_tag)); // R3
    AST_MISALIGN_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        misal |-> !mem_req_valid); // R9
    AST_MISALIGN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        misal |=> align_fault); // R9
    AST_TAGGED_STORE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd4 && src_tag) |-> !mem_req_valid); // R6
    AST_TAGGED_STORE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd4 && src_tag) |=> consume_fault); // R6
    AST_TAGGED_SPILL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sf_op && op_code == 4'd5 && !misal && src_tag)
        |-> (mem_req_valid && mem_req_write && mem_wdata == '0)); // R7
    AST_FAULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({align_fault, consume_fault})); // R9
    AST_TEST_FROM_OP: assert property (@(posedge clk) disable iff (!rst_n)
        tag_test_valid |-> $past(op_valid && op_code == 4'd7)); // R11
    AST_RECOVER_FROM_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        recover_req |-> $past(op_valid && op_code == 4'd8 && src_tag)); // R12

endmodule

bind tagreg_spill_unit tsu_chk #(.NREG(NREG), .DW(DW), .AW(AW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .op_valid       (op_valid),
    .op_code        (op_code),
    .op_addr        (op_addr),
    .src_tag        (src_tag),
    .rd_idx         (rd_idx),
    .rd_data        (rd_data),
    .rd_tag         (rd_tag),
    .mem_req_valid  (mem_req_valid),
    .mem_req_write  (mem_req_write),
    .mem_wdata      (mem_wdata),
    .align_fault    (align_fault),
    .consume_fault  (consume_fault),
    .tag_test_valid (tag_test_valid),
    .recover_req    (recover_req)
);

// File: tb/tagreg_spill_unit_tb.sv
// Self-checking bench with a behavioural reference model compared each step.
module tagreg_spill_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [3:0]  op_code;
    logic [4:0]  op_rd, op_rs, rd_idx;
    logic [15:0] op_addr, mem_addr;
    logic [63:0] op_wdata, rd_data, mem_wdata, mem_rdata, coll_wdata, coll_rdata;
    logic        rd_tag, mem_req_valid, mem_req_write, mem_fault, coll_wr_en;
    logic        tag_test_valid, tag_test_result, recover_req, consume_fault, align_fault;

    always #(CLK_PERIOD/2) clk = ~clk;

    tagreg_spill_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_rd(op_rd), .op_rs(op_rs), .op_addr(op_addr), .op_wdata(op_wdata),
        .rd_idx(rd_idx), .rd_data(rd_data), .rd_tag(rd_tag),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_fault(mem_fault), .coll_wr_en(coll_wr_en), .coll_wdata(coll_wdata),
        .coll_rdata(coll_rdata), .tag_test_valid(tag_test_valid),
        .tag_test_result(tag_test_result), .recover_req(recover_req),
        .consume_fault(consume_fault), .align_fault(align_fault)
    );

    // Bench memory, answering in the same cycle.
    logic [63:0] bmem [0:511];
    assign mem_rdata = bmem[mem_addr[11:3]];
    always @(posedge clk) begin
        if (mem_req_valid && mem_req_write) bmem[mem_addr[11:3]] <= mem_wdata;
    end

    // Reference model state.
    logic [63:0] m_data [0:31];
    logic        m_tag  [0:31];
    logic [63:0] m_coll;
    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One operation: drive, check request, update model, check results.
    task automatic step(input logic [3:0] op, input int rd, input int rs,
                        input logic [15:0] addr, input logic [63:0] wd,
                        input logic flt, input logic cwe, input logic [63:0] cwd,
                        input string req);
        logic        e_v, e_w, e_al, e_cons, e_tv, e_tb, e_rec;
        logic [63:0] e_wd, rdv;
        logic        al;
        @(negedge clk);
        op_valid = 1'b1; op_code = op; op_rd = 5'(rd); op_rs = 5'(rs);
        op_addr = addr; op_wdata = wd; mem_fault = flt;
        coll_wr_en = cwe; coll_wdata = cwd; rd_idx = 5'(rd);
        al = (addr[2:0] == 3'b0);
        e_v = 0; e_w = 0; e_wd = 0; e_al = 0; e_cons = 0; e_tv = 0; e_tb = 0; e_rec = 0;
        case (op)
            4'd2, 4'd3: e_v = 1;
            4'd4: if (m_tag[rs]) e_cons = 1; else begin e_v = 1; e_w = 1; e_wd = m_data[rs]; end
            4'd5: if (!al) e_al = 1; else begin e_v = 1; e_w = 1; e_wd = m_tag[rs] ? 64'd0 : m_data[rs]; end
            4'd6: if (!al) e_al = 1; else e_v = 1;
            4'd7: begin e_tv = 1; e_tb = m_tag[rs]; end
            4'd8: e_rec = m_tag[rs];
            default: ;
        endcase
        #1;
        chk({req, " req_valid"}, 64'(mem_req_valid), 64'(e_v));
        if (e_v) begin
            chk({req, " req_write"}, 64'(mem_req_write), 64'(e_w));
            chk({req, " req_addr"}, 64'(mem_addr), 64'(addr));
            if (e_w) chk({req, " req_wdata"}, mem_wdata, e_wd);
        end
        rdv = mem_rdata;
        @(posedge clk);
        if (cwe) m_coll = cwd;
        case (op)
            4'd1: if (rd != 0) begin m_data[rd] = wd; m_tag[rd] = 0; end
            4'd2: if (rd != 0) begin m_data[rd] = rdv; m_tag[rd] = 0; end
            4'd3: if (rd != 0) begin m_data[rd] = flt ? 64'd0 : rdv; m_tag[rd] = flt; end
            4'd5: if (al) m_coll[addr[8:3]] = m_tag[rs];
            4'd6: if (al && rd != 0) begin m_data[rd] = rdv; m_tag[rd] = m_coll[addr[8:3]]; end
            default: ;
        endcase
        @(negedge clk);
        chk({req, " align_fault"}, 64'(align_fault), 64'(e_al));
        chk({req, " consume_fault"}, 64'(consume_fault), 64'(e_cons));
        chk({req, " test_valid"}, 64'(tag_test_valid), 64'(e_tv));
        chk({req, " test_result"}, 64'(tag_test_result), 64'(e_tb));
        chk({req, " recover"}, 64'(recover_req), 64'(e_rec));
        chk({req, " coll"}, coll_rdata, m_coll);
        chk({req, " rd_data"}, rd_data, m_data[rd]);
        chk({req, " rd_tag"}, 64'(rd_tag), 64'(m_tag[rd]));
        op_valid = 1'b0; coll_wr_en = 1'b0; mem_fault = 1'b0;
    endtask

    // Read every register through the read port.
    task automatic sweep(input string req);
        for (int i = 0; i < 32; i++) begin
            rd_idx = 5'(i);
            #1;
            chk({req, " sweep data"}, rd_data, m_data[i]);
            chk({req, " sweep tag"}, 64'(rd_tag), 64'(m_tag[i]));
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    localparam logic [63:0] VA = 64'hA5A5_0123_4567_89AB;
    localparam logic [63:0] VB = 64'h1111_2222_3333_4444;

    initial begin
        for (int i = 0; i < 512; i++) bmem[i] = {32'hC0DE_0000 + 32'(i), 32'(i) * 32'h9E37};
        for (int i = 0; i < 32; i++) begin m_data[i] = 0; m_tag[i] = 0; end
        m_coll = 0;
        rst_n = 0; op_valid = 0; op_code = 0; op_rd = 0; op_rs = 0; op_addr = 0;
        op_wdata = 0; rd_idx = 0; mem_fault = 0; coll_wr_en = 0; coll_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        #1;
        chk("R1 coll", coll_rdata, 64'd0);
        chk("R1 req", 64'(mem_req_valid), 64'd0);
        chk("R1 flags", 64'({align_fault, consume_fault, tag_test_valid, recover_req}), 64'd0);
        sweep("R1");
        // R2 writes, R3 write to zero register ignored
        step(4'd1, 1, 0, 16'h0, VA, 0, 0, 0, "R2 write r1");
        step(4'd1, 2, 0, 16'h0, VB, 0, 0, 0, "R2 write r2");
        step(4'd1, 0, 0, 16'h0, VB, 0, 0, 0, "R3 write r0");
        // R6 untagged store, R4 load
        step(4'd4, 0, 1, 16'h0100, 0, 0, 0, 0, "R6 store r1");
        step(4'd2, 3, 0, 16'h0100, 0, 0, 0, 0, "R4 load r3");
        // R5 speculative loads
        step(4'd3, 4, 0, 16'h0108, 0, 1, 0, 0, "R5 spec fault r4");
        step(4'd3, 5, 0, 16'h0110, 0, 0, 0, 0, "R5 spec ok r5");
        // R11 tag tests, R12 checks
        step(4'd7, 0, 4, 16'h0, 0, 0, 0, 0, "R11 test r4");
        step(4'd7, 0, 3, 16'h0, 0, 0, 0, 0, "R11 test r3");
        step(4'd8, 0, 4, 16'h0, 0, 0, 0, 0, "R12 check r4");
        step(4'd8, 0, 3, 16'h0, 0, 0, 0, 0, "R12 check r3");
        // R6 tagged store blocked; memory unchanged seen by later load
        step(4'd4, 0, 4, 16'h0100, 0, 0, 0, 0, "R6 store tagged");
        step(4'd2, 9, 0, 16'h0100, 0, 0, 0, 0, "R6 memory kept");
        chk("R6 memory kept value", m_data[9], VA);
        // R7 spills
        step(4'd5, 0, 4, 16'h01F8, 0, 0, 0, 0, "R7 spill tagged");
        step(4'd5, 0, 1, 16'h0010, 0, 0, 0, 0, "R7 spill r1");
        chk("R7 coll bit63", 64'(coll_rdata[63]), 64'd1);
        // R9 misaligned spill and fill
        step(4'd5, 0, 4, 16'h0013, 0, 0, 0, 0, "R9 spill misaligned");
        step(4'd6, 6, 0, 16'h01FC, 0, 0, 0, 0, "R9 fill misaligned");
        // R8 fills
        step(4'd6, 6, 0, 16'h01F8, 0, 0, 0, 0, "R8 fill tagged");
        step(4'd6, 7, 0, 16'h0010, 0, 0, 0, 0, "R8 fill clean");
        chk("R8 r6 tag", 64'(m_tag[6]), 64'd1);
        // R10 software load, then collision with a spill
        step(4'd0, 0, 0, 16'h0, 0, 0, 1, 64'h0000_0000_0000_0400, "R10 sw load");
        step(4'd5, 0, 6, 16'h0028, 0, 0, 1, 64'hFFFF_0000_0000_0400, "R10 spill wins");
        chk("R10 bit5", 64'(coll_rdata[5]), 64'd1);
        step(4'd6, 8, 0, 16'h0050, 0, 0, 0, 0, "R8 fill sw bit");
        // R3 fill into r0, R2 and R4 clear tags
        step(4'd6, 0, 0, 16'h0050, 0, 0, 0, 0, "R3 fill r0");
        step(4'd1, 6, 0, 16'h0, VB, 0, 0, 0, "R2 write clears tag");
        step(4'd2, 8, 0, 16'h0118, 0, 0, 0, 0, "R4 load clears tag");
        step(4'd12, 5, 3, 16'h0, VA, 0, 0, 0, "R2 unused code");
        sweep("final");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule